// File: doc/BRIEF.md
# Dual-Mode Control Word Loader

This block collects a 40-bit synthesizer control word from a slow external host. It then presents the word as a 32-bit tuning word, a 5-bit phase word and a power-down flag. The host drives two strobes, a write strobe and an update strobe, together with an 8-bit data bus. A mode input selects how the write strobe is used. In parallel mode each write strobe stores one byte, and an internal pointer picks the byte and then advances by one. In serial mode each write strobe shifts one bit from the top data line into the same staging word.

The outputs keep their value while bytes or bits are being gathered. They change only when the update strobe rises. At that point the whole staging word is copied to the outputs at once, and the byte pointer and the bit counter go back to the start. The strobes and the mode input come from another clock domain. Each passes through a two-flop synchronizer, and only its rising edges (for the mode input, its changes) take effect.

Top module: `ctrl_word_loader`

## Requirements
- R1: A synchronous reset drives tune_word, phase_word and pwr_down to zero and clears the staging word. An update after reset with no writes in between therefore still gives all zeros.
- R2: In parallel mode the k-th byte written after a commit goes to byte slot k. Slot 0 holds phase_word in bits 7:3, pwr_down in bit 2 and two spare control bits in bits 1:0. Slots 1 to 4 hold tune_word from the most significant byte to the least significant byte.
- R3: Outputs do not change between update edges, whatever writes take place.
- R4: After five byte writes, later parallel write edges leave the staging word unchanged until the next update edge, reset or mode change. Slots not written since the last commit keep their previous contents.
- R5: An update edge copies the staging word to the outputs and rewinds the byte pointer, so the next write goes to slot 0.
- R6: In serial mode each write edge shifts din[7] in, and din[6:0] is ignored. After 40 shifts, the first bit shifted sits at tune_word bit 0, bit 31 at tune_word bit 31, bits 32 and 33 in the spare bits, bit 34 at pwr_down, and bits 35 to 39 at phase_word bits 0 to 4.
- R7: After 40 serial shifts, later write edges are ignored until an update edge, reset or mode change.
- R8: When a write edge and an update edge are detected in the same cycle, the update is performed and the write is dropped: nothing is stored and the pointer does not move.
- R9: A change of the mode input rewinds the byte pointer and the bit counter. The contents of the staging word are kept.
- R10: Strobes act on their rising edge only. A strobe held high for many cycles counts as one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 selects serial loading, 0 selects byte loading (asynchronous) |
| wr_strobe | input | 1 | Write strobe (asynchronous) |
| upd_strobe | input | 1 | Update strobe that commits the staging word (asynchronous) |
| din | input | 8 | Byte data; in serial mode only din[7] is used |
| tune_word | output | 32 | Active tuning word |
| phase_word | output | 5 | Active phase word |
| pwr_down | output | 1 | Active power-down flag |

## Verification
The hardest case to reach is a write edge and an update edge in the same detected cycle. The bench gets there by raising both strobes on the same clock. The synchronizer chains are identical, so both edges appear together. A dropped write cannot be seen directly, so the bench first moves the pointer partway and then does the simultaneous pulse. It then writes a full fresh set of five bytes and commits. If the write had been accepted, the pointer would have moved and the fresh bytes would have landed in the wrong slots. Pointer saturation is covered in the same way, by sweeping from one to seven writes between commits and checking which slots keep their old contents.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;
endpackage

// File: rtl/cwl_edge_sync.sv
module cwl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic toggle
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_in};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl    = chain_q[STAGES-1];
  assign rise   = lvl & ~last_q;
  assign toggle = lvl ^ last_q;

  // R10: a detected edge is a single-cycle event
  p_single_rise_r10: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/cwl_sat_ctr.sv
module cwl_sat_ctr #(
  parameter int LIMIT = 5,
  parameter int CW    = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst || clr)        cnt <= '0;
    else if (inc && !full) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == CW'(LIMIT));

  p_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(LIMIT));
  p_clear_rewinds_r5: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  p_saturate_r7: assert property (@(posedge clk) disable iff (rst)
    (full && inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/cwl_stage_reg.sv
module cwl_stage_reg #(
  parameter int NUM_BYTES = 5,
  parameter int BYTE_W    = 8,
  parameter int IDX_W     = 3,
  parameter int WORD_W    = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_we,
  input  logic [IDX_W-1:0]  byte_idx,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [WORD_W-1:0] word
);
  logic [BYTE_W-1:0] slice_q [NUM_BYTES];
  logic [WORD_W-1:0] shifted;

  assign shifted = {shift_bit, word[WORD_W-1:1]};

  // slot k lives in slice NUM_BYTES-1-k: slot 0 on top, last slot at bit 0
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slice
    always_ff @(posedge clk) begin
      if (rst)
        slice_q[g] <= '0;
      else if (byte_we && byte_idx == IDX_W'(NUM_BYTES - 1 - g))
        slice_q[g] <= byte_in;
      else if (shift_en)
        slice_q[g] <= shifted[g*BYTE_W +: BYTE_W];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BYTES; i++) word[i*BYTE_W +: BYTE_W] = slice_q[i];
  end

  p_one_source_r8: assert property (@(posedge clk) disable iff (rst)
    !(byte_we && shift_en));
endmodule

// File: rtl/ctrl_word_loader.sv
module ctrl_word_loader
  import cwl_pkg::*;
#(
  parameter int TUNE_W      = 32,
  parameter int PHASE_W     = 5,
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ser_mode,
  input  logic               wr_strobe,
  input  logic               upd_strobe,
  input  logic [BYTE_W-1:0]  din,
  output logic [TUNE_W-1:0]  tune_word,
  output logic [PHASE_W-1:0] phase_word,
  output logic               pwr_down
);
  localparam int WORD_W = NUM_BYTES * BYTE_W;
  localparam int PTR_W  = $clog2(NUM_BYTES + 1);
  localparam int BIT_W  = $clog2(WORD_W + 1);
  localparam int PD_POS = WORD_W - PHASE_W - 1;

  logic wr_lvl, wr_rise, wr_tog;
  logic up_lvl, up_rise, up_tog;
  logic md_lvl, md_rise, md_tog;

  cwl_edge_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst(rst), .async_in(wr_strobe),
    .lvl(wr_lvl), .rise(wr_rise), .toggle(wr_tog));
  cwl_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst(rst), .async_in(upd_strobe),
    .lvl(up_lvl), .rise(up_rise), .toggle(up_tog));
  cwl_edge_sync #(.STAGES(SYNC_STAGES)) u_md_sync (
    .clk(clk), .rst(rst), .async_in(ser_mode),
    .lvl(md_lvl), .rise(md_rise), .toggle(md_tog));

  load_mode_e mode;
  assign mode = load_mode_e'(md_lvl);

  logic              ctr_clr, wr_ok, par_we, ser_en, ptr_full, bit_full;
  logic [PTR_W-1:0]  ptr;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] stage_word;

  assign ctr_clr = up_rise | md_tog;
  assign wr_ok   = wr_rise & ~up_rise & ~md_tog;
  assign par_we  = wr_ok & (mode == LOAD_PAR) & ~ptr_full;
  assign ser_en  = wr_ok & (mode == LOAD_SER) & ~bit_full;

  cwl_sat_ctr #(.LIMIT(NUM_BYTES), .CW(PTR_W)) u_ptr (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(par_we),
    .cnt(ptr), .full(ptr_full));
  cwl_sat_ctr #(.LIMIT(WORD_W), .CW(BIT_W)) u_bits (
    .clk(clk), .rst(rst), .clr(ctr_clr), .inc(ser_en),
    .cnt(bit_cnt), .full(bit_full));

  cwl_stage_reg #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .IDX_W(PTR_W)) u_stage (
    .clk(clk), .rst(rst), .byte_we(par_we), .byte_idx(ptr), .byte_in(din),
    .shift_en(ser_en), .shift_bit(din[BYTE_W-1]), .word(stage_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      tune_word  <= '0;
      phase_word <= '0;
      pwr_down   <= 1'b0;
    end else if (up_rise) begin
      tune_word  <= stage_word[TUNE_W-1:0];
      phase_word <= stage_word[WORD_W-1 -: PHASE_W];
      pwr_down   <= stage_word[PD_POS];
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (tune_word == '0 && phase_word == '0 && !pwr_down));
  p_hold_outputs_r3: assert property (@(posedge clk) disable iff (rst)
    !up_rise |=> $stable({tune_word, phase_word, pwr_down}));
  p_commit_copy_r5: assert property (@(posedge clk) disable iff (rst)
    up_rise |=> (tune_word == $past(stage_word[TUNE_W-1:0])));
  p_full_bytes_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && mode == LOAD_PAR && ptr_full && !up_rise && !md_tog)
      |=> $stable(stage_word));
  p_full_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && mode == LOAD_SER && bit_full && !up_rise && !md_tog)
      |=> $stable(stage_word));
  p_update_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_rise && up_rise) |=> ($stable(stage_word) && ptr == '0));
  p_mode_rewind_r9: assert property (@(posedge clk) disable iff (rst)
    md_tog |=> (ptr == '0 && bit_cnt == '0));
endmodule

// File: tb/tb_ctrl_word_loader.sv
module tb_ctrl_word_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_mode = 1'b0;
  logic        wr_strobe = 1'b0;
  logic        upd_strobe = 1'b0;
  logic [7:0]  din = '0;
  logic [31:0] tune_word;
  logic [4:0]  phase_word;
  logic        pwr_down;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] slot [5];

  always #2 clk = ~clk;

  ctrl_word_loader dut (
    .clk(clk), .rst(rst), .ser_mode(ser_mode), .wr_strobe(wr_strobe),
    .upd_strobe(upd_strobe), .din(din), .tune_word(tune_word),
    .phase_word(phase_word), .pwr_down(pwr_down));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input bit w, input bit u, input logic [7:0] d, input int hi);
    @(negedge clk);
    din = d;
    wr_strobe = w;
    upd_strobe = u;
    tick(hi);
    wr_strobe = 1'b0;
    upd_strobe = 1'b0;
    tick(5);
  endtask

  task automatic set_mode(input bit m);
    @(negedge clk);
    ser_mode = m;
    tick(8);
  endtask

  function automatic logic [37:0] from_slots();
    return {slot[0][7:3], slot[0][2], slot[1], slot[2], slot[3], slot[4]};
  endfunction

  task automatic check(input string req, input logic [37:0] exp);
    logic [37:0] act;
    act = {phase_word, pwr_down, tune_word};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [37:0] prev;
    logic [39:0] s;
    logic [7:0]  fresh [5];
    for (int k = 0; k < 5; k++) slot[k] = '0;
    tick(4);
    rst = 1'b0;
    tick(2);
    check("R1 reset", '0);

    // R2/R3: full parallel loads, several patterns
    for (int p = 0; p < 6; p++) begin
      prev = from_slots();
      for (int k = 0; k < 5; k++) begin
        slot[k] = 8'(p * 37 + k * 53 + 1);
        pulse(1'b1, 1'b0, slot[k], 4);
      end
      check("R3 hold before update", prev);
      pulse(1'b0, 1'b1, 8'h00, 4);
      check("R2 parallel layout", from_slots());
    end

    // R4/R5: sweep write counts, saturation and rewind
    for (int n = 1; n <= 7; n++) begin
      for (int k = 0; k < n; k++) begin
        logic [7:0] v;
        v = 8'(8'hA5 ^ (n * 16 + k * 3));
        if (k < 5) slot[k] = v;
        pulse(1'b1, 1'b0, v, 4);
      end
      pulse(1'b0, 1'b1, 8'h00, 4);
      check("R4 saturation / R5 rewind", from_slots());
    end

    // R10: long strobe counts once
    for (int k = 0; k < 5; k++) slot[k] = 8'(8'h11 * (k + 3));
    pulse(1'b1, 1'b0, slot[0], 30);
    for (int k = 1; k < 5; k++) pulse(1'b1, 1'b0, slot[k], 4);
    pulse(1'b0, 1'b1, 8'h00, 30);
    check("R10 edge only", from_slots());

    // R8: simultaneous write and update
    pulse(1'b1, 1'b0, 8'h3C, 4);
    pulse(1'b1, 1'b0, 8'hC3, 4);
    slot[0] = 8'h3C;
    slot[1] = 8'hC3;
    pulse(1'b1, 1'b1, 8'hEE, 4);
    check("R8 update taken", from_slots());
    for (int k = 0; k < 5; k++) begin
      fresh[k] = 8'(8'h5A + k * 29);
      slot[k] = fresh[k];
      pulse(1'b1, 1'b0, fresh[k], 4);
    end
    pulse(1'b0, 1'b1, 8'h00, 4);
    check("R8 write dropped", from_slots());

    // R9: mode change rewinds pointer
    pulse(1'b1, 1'b0, 8'h77, 4);
    pulse(1'b1, 1'b0, 8'h88, 4);
    set_mode(1'b1);
    set_mode(1'b0);
    for (int k = 0; k < 5; k++) begin
      slot[k] = 8'(8'h90 + k * 7);
      pulse(1'b1, 1'b0, slot[k], 4);
    end
    pulse(1'b0, 1'b1, 8'h00, 4);
    check("R9 mode rewind", from_slots());

    // R6/R7: serial loads with extra ignored bits
    set_mode(1'b1);
    for (int p = 0; p < 4; p++) begin
      s = 40'(64'hD1B5_4A32_9C * (p + 1) + p);
      for (int i = 0; i < 40; i++)
        pulse(1'b1, 1'b0, {s[i], 7'(~s[i] ? 7'h7F : 7'h00)}, 3);
      for (int i = 0; i < 3; i++)
        pulse(1'b1, 1'b0, {~s[39 - i], 7'h55}, 3);
      pulse(1'b0, 1'b1, 8'h00, 4);
      check("R6 serial order / R7 extra bits ignored", {s[39:35], s[34], s[31:0]});
    end
    set_mode(1'b0);

    // R1: reset mid-load clears staging
    pulse(1'b1, 1'b0, 8'hFF, 4);
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(2);
    check("R1 outputs after reset", '0);
    pulse(1'b0, 1'b1, 8'h00, 4);
    check("R1 staging cleared", '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule